// File: doc/BRIEF.md
# Brightness-Proportional Level Glider

This block walks a 15-bit output level toward a target level, a little on every tick strobe. The size of each tick's move scales with the current brightness: a dim level moves by a single unit per tick, and a bright level moves by up to 64 units. On a perceptual scale the glide therefore looks even from the bottom of the range to the top. The output level drives a dithered PWM stage downstream. A done flag tells the controller when the level has arrived.

A controller writes a new goal through the load strobe and then issues ticks at its frame rate. Inside a tick the block performs its unit moves one per clock. The output level and the done flag change only when the whole tick has finished. A tick that arrives during that work is dropped.

Top module: `glide_ramp`

## Requirements
- R1: After a synchronous reset, the level output is 0 and done is 1. The stored target is also 0.
- R2: A load pulse stores target_i as the goal. The goal takes effect at that clock edge. When the block is idle, done reflects the new goal at that same edge.
- R3: An accepted tick performs N = (level >> 9) + 1 unit moves. The level used is the value at the tick's start, and N is not recomputed between moves. The level then ends at the start value moved toward the goal by min(N, distance). For example, 1024 toward 2000 gives 1027.
- R4: While the block is idle, done is 1 exactly when the level output equals the stored goal.
- R5: The level never passes the goal. Unit moves that remain after the goal is reached change nothing. For example, 1027 toward 1028 gives 1028.
- R6: Downward glides follow the same count rule. For example, 1028 toward 1020 gives 1025.
- R7: Let the tick be sampled at edge E, with N moves. Then level_o and done stay unchanged through edge E+N-1 and take their new values at edge E+N.
- R8: A tick that arrives while an earlier tick is still in progress is ignored. It does not restart the work and it does not add moves.
- R9: A load during a tick in progress does not change the goal that this tick moves toward. The next tick uses the new goal.
- R10: At the top level of 32640 the step count is 63. A tick then makes 64 unit moves, so 32640 toward 0 gives 32576, reached 64 edges after the tick is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Tick strobe; one tick per cycle high |
| load_i | input | 1 | Stores target_i as the goal |
| target_i | input | 15 | New goal level |
| level_o | output | 15 | Current level, registered |
| done_o | output | 1 | Level equals goal, registered |

## Verification
Let the tick be sampled at edge E. The glide result is due exactly N edges after E, where N is one plus the starting level shifted right by nine. For that reason the directed checks sample level_o at the falling edge after each of edges E through E+N-1 and expect the old value. They then expect the new value one falling edge later. A load is due at its own edge, so done is checked at the next falling edge. A behavioural model keeps the goal, a pending final value and a countdown of remaining edges. It is compared with level_o and done_o at every falling edge, so any cycle of early or late update is caught.

// File: rtl/glide_pkg.sv
package glide_pkg;
  typedef enum logic [1:0] {
    MOVE_HOLD = 2'd0,
    MOVE_UP   = 2'd1,
    MOVE_DOWN = 2'd2
  } move_e;
endpackage

// File: rtl/glide_count.sv
module glide_count #(
  parameter int LVL_W = 15,
  parameter int SHIFT = 9,
  localparam int CNT_W = LVL_W - SHIFT
) (
  input  logic [LVL_W-1:0] level,
  output logic [CNT_W-1:0] count
);
  // brighter levels get more unit moves per tick
  assign count = level[LVL_W-1:SHIFT];
endmodule

// File: rtl/glide_unit.sv
module glide_unit
  import glide_pkg::*;
#(
  parameter int LVL_W = 15
) (
  input  logic [LVL_W-1:0] cur,
  input  logic [LVL_W-1:0] goal,
  output logic [LVL_W-1:0] nxt,
  output move_e            move
);
  localparam logic [LVL_W-1:0] ONE = {{(LVL_W-1){1'b0}}, 1'b1};

  always_comb begin
    if (cur < goal) begin
      move = MOVE_UP;
      nxt  = cur + ONE;
    end else if (cur > goal) begin
      move = MOVE_DOWN;
      nxt  = cur - ONE;
    end else begin
      move = MOVE_HOLD;
      nxt  = cur;
    end
  end
endmodule

// File: rtl/glide_seq.sv
module glide_seq #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] count,
  output logic             busy,
  output logic             start,
  output logic             last
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] rem_q;
  logic             busy_q;

  assign busy  = busy_q;
  assign start = tick && !busy_q;
  assign last  = busy_q && (rem_q == ZERO);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      rem_q  <= ZERO;
    end else if (start) begin
      busy_q <= 1'b1;
      rem_q  <= count;
    end else if (busy_q) begin
      if (rem_q == ZERO) busy_q <= 1'b0;
      else               rem_q  <= rem_q - ONE;
    end
  end

  AST_TICK_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy_q && rem_q != ZERO) |=> (busy_q && rem_q == $past(rem_q) - ONE)); // R8

  AST_SEQ_ENDS: assert property (@(posedge clk) disable iff (rst)
    last |=> !busy_q); // R7
endmodule

// File: rtl/glide_ramp.sv
module glide_ramp
  import glide_pkg::*;
#(
  parameter int LVL_W = 15,
  parameter int SHIFT = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [LVL_W-1:0] target_i,
  output logic [LVL_W-1:0] level_o,
  output logic             done_o
);
  localparam int CNT_W = LVL_W - SHIFT;
  localparam logic [LVL_W-1:0] ONE = {{(LVL_W-1){1'b0}}, 1'b1};

  logic [LVL_W-1:0] level_q, goal_q, work_q, wgoal_q;
  logic [LVL_W-1:0] goal_nxt, level_nxt, step_nxt;
  logic [CNT_W-1:0] count;
  logic             done_q, busy, start, last;
  move_e            move;

  glide_count #(.LVL_W(LVL_W), .SHIFT(SHIFT)) u_count (
    .level(level_q), .count(count)
  );

  glide_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .tick(tick_i), .count(count),
    .busy(busy), .start(start), .last(last)
  );

  glide_unit #(.LVL_W(LVL_W)) u_unit (
    .cur(work_q), .goal(wgoal_q), .nxt(step_nxt), .move(move)
  );

  assign goal_nxt  = load_i ? target_i : goal_q;
  assign level_nxt = last ? step_nxt : level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
      goal_q  <= '0;
      work_q  <= '0;
      wgoal_q <= '0;
      done_q  <= 1'b1;
    end else begin
      goal_q <= goal_nxt;
      if (start) begin
        work_q  <= level_q;
        wgoal_q <= goal_nxt;
      end else if (busy) begin
        work_q  <= step_nxt;
      end
      level_q <= level_nxt;
      if (!busy || last) done_q <= (level_nxt == goal_nxt);
    end
  end

  assign level_o = level_q;
  assign done_o  = done_q;

  AST_DONE_MATCH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (done_q == (level_q == goal_q))); // R4

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    busy |-> $stable(level_q)); // R7

  AST_NO_OVERSHOOT_UP: assert property (@(posedge clk) disable iff (rst)
    (busy && work_q <= wgoal_q) |=> (work_q <= wgoal_q)); // R5

  AST_NO_OVERSHOOT_DN: assert property (@(posedge clk) disable iff (rst)
    (busy && work_q >= wgoal_q) |=> (work_q >= wgoal_q)); // R5

  AST_UNIT_MOVE: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy) |->
      (work_q == $past(work_q) || work_q == $past(work_q) + ONE ||
       work_q + ONE == $past(work_q))); // R3

  AST_GOAL_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> $stable(wgoal_q)); // R9

  AST_MOVE_KNOWN: assert property (@(posedge clk) disable iff (rst)
    (move != MOVE_UP) || (work_q < wgoal_q)); // R5
endmodule

// File: tb/glide_ramp_bench.sv
module glide_ramp_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic        load_i = 1'b0;
  logic [14:0] target_i = '0;
  logic [14:0] level_o;
  logic        done_o;

  int checks = 0;
  int failures = 0;

  int m_lvl, m_goal, m_fin, m_cnt;
  bit m_busy, m_done;

  always #10 clk = ~clk;

  glide_ramp u_glide_ramp (
    .clk(clk), .rst(rst), .tick_i(tick_i), .load_i(load_i),
    .target_i(target_i), .level_o(level_o), .done_o(done_o)
  );

  // behavioural reference: goal, pending final value, remaining edges
  always @(posedge clk) begin
    if (rst) begin
      m_lvl = 0; m_goal = 0; m_busy = 0; m_done = 1; m_cnt = 0; m_fin = 0;
    end else begin
      if (load_i) m_goal = int'(target_i);
      if (m_busy) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          m_lvl = m_fin; m_busy = 0; m_done = (m_lvl == m_goal);
        end
      end else begin
        m_done = (m_lvl == m_goal);
        if (tick_i) begin
          int n;
          n = (m_lvl >> 9) + 1;
          if (m_goal > m_lvl)      m_fin = m_lvl + ((m_goal - m_lvl) < n ? (m_goal - m_lvl) : n);
          else if (m_goal < m_lvl) m_fin = m_lvl - ((m_lvl - m_goal) < n ? (m_lvl - m_goal) : n);
          else                     m_fin = m_lvl;
          m_cnt = n; m_busy = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (int'(level_o) != m_lvl || done_o != m_done) begin
        failures++;
        $display("FAIL R3 R4 R7 model: level=%0d done=%0d expected level=%0d done=%0d",
                 level_o, done_o, m_lvl, m_done);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_load(input int v);
    @(negedge clk); load_i = 1'b1; target_i = 15'(v);
    @(negedge clk); load_i = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    while (m_busy) @(negedge clk);
  endtask

  task automatic tick_timed(input string req, input int steps, input int st, input int fin);
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    for (int j = 0; j < steps; j++) begin
      check(req, int'(level_o), st);
      @(negedge clk);
    end
    check(req, int'(level_o), fin);
  endtask

  task automatic ramp_until_done();
    while (!done_o) do_tick();
  endtask

  initial begin
    #4000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 level", int'(level_o), 0);
    check("R1 done", int'(done_o), 1);

    do_load(1024);
    check("R2 done after load", int'(done_o), 0);
    tick_timed("R7 level0 one edge", 1, 0, 1);
    ramp_until_done();
    check("R4 reached 1024", int'(level_o), 1024);
    check("R4 done at goal", int'(done_o), 1);

    do_load(2000);
    tick_timed("R3 1024 up", 3, 1024, 1027);
    do_load(1028);
    tick_timed("R5 clamp", 3, 1027, 1028);
    check("R5 done", int'(done_o), 1);
    do_load(1020);
    tick_timed("R6 down", 3, 1028, 1025);

    // R8: second tick while busy
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    while (m_busy) @(negedge clk);
    repeat (5) @(negedge clk);
    check("R8 single tick applied", int'(level_o), 1022);
    check("R8 done low", int'(done_o), 0);

    // R9: load mid-tick does not redirect it
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0; load_i = 1'b1; target_i = 15'd1000;
    @(negedge clk); load_i = 1'b0;
    while (m_busy) @(negedge clk);
    check("R9 frozen goal", int'(level_o), 1020);
    check("R9 done vs new goal", int'(done_o), 0);
    tick_timed("R9 next tick new goal", 2, 1020, 1018);

    do_load(32640);
    ramp_until_done();
    check("R10 top reached", int'(level_o), 32640);
    do_load(0);
    tick_timed("R10 64 moves", 64, 32640, 32576);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule